// File: doc/BRIEF.md
# Token-Ring Cascaded FIFO

This block builds one deep first-in first-out queue out of several identical storage slices that sit on a single write port and a single read port. The slices are linked in a closed ring by expansion signals. Two ownership tokens travel around the ring, one for writing and one for reading. The slice that holds the write token takes every accepted word until its last location has been written. It then pulses its write expansion output and hands the token to the next slice. The read token moves in the same way. Because the word order is spread across the slices in blocks, the slices together act as one circular buffer of `N_SLICES * SLICE_DEPTH` words.

The data path uses valid/ready handshakes. A word is written on a rising edge where `in_valid` and `in_ready` are both high. A producer that sees `in_ready` low must hold its word and retry, and the block applies back-pressure only when every slice is full. The head word is always present on `out_data` while `out_valid` is high. It is consumed on a rising edge where `out_valid` and `out_ready` are both high, and the consumer may hold `out_ready` high with no penalty. The composite active-low status flags `full_n` and `empty_n` are also brought out as plain pins. Each one is formed by OR-ing the matching per-slice flag. The slice that owns both tokens after reset is chosen by a parameter, which drives that slice's active-low first-load input low; every other slice has the input held high.

Top module: `token_ring_fifo`

## Requirements
- R1: The queue holds exactly `N_SLICES * SLICE_DEPTH` words. With no reads, `in_ready` stays high for that many accepted writes and then goes low.
- R2: Words leave in strict arrival order, including across the boundaries between slices and across the wrap from the last slice back to the first.
- R3: A write offered while the queue is full (`in_ready` low) is dropped. No token moves and no stored word changes.
- R4: A read request while the queue is empty (`out_valid` low) has no effect. A word written afterwards is the next word read.
- R5: While `rst_n` is low and after its release, the queue is empty: `empty_n`=0, `out_valid`=0, `full_n`=1, `in_ready`=1. Both tokens are in slice `FIRST_SLICE`, and the stored contents are discarded.
- R6: Exactly one slice holds the write token and exactly one holds the read token at all times. A slice that uses its last location pulses its expansion output in that cycle. In the next cycle the token is in the next slice of the ring, index (i+1) mod `N_SLICES`, and otherwise the token stays where it is.
- R7: `out_data` is the OR of all slice outputs. Slices without the read token drive all zeros, so `out_data` shows the head word whenever `out_valid` is 1.
- R8: A write and a read accepted in the same cycle are both performed, even when they hit the same slice. The occupancy is unchanged after that cycle.
- R9: `full_n` (active low) is 0 only when every slice is full, and `empty_n` (active low) is 0 only when every slice is empty. `in_ready` equals `full_n` and `out_valid` equals `empty_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Producer offers `in_data` |
| in_ready | output | 1 | Queue can accept a word (not full) |
| in_data | input | DATA_W | Word to store |
| out_valid | output | 1 | Head word present on `out_data` |
| out_ready | input | 1 | Consumer takes the head word |
| out_data | output | DATA_W | Head word (OR of slice outputs) |
| full_n | output | 1 | Composite full flag, active low |
| empty_n | output | 1 | Composite empty flag, active low |

## Verification
The bench keeps its own queue model and drives long random stretches with unequal write and read rates, so the tokens go around the ring many times. Simultaneous read and write in the same slice is one of the cases this covers. A design that passes a token one cycle late would drop or misplace the word at each slice boundary, and that would show up as out-of-order data. Directed cases fill the queue to exactly its capacity and then push an extra word at it. A wrong composite flag would either stop early or overwrite the oldest slice. The directed cases also read from an empty queue: a design that moved its read pointer there would later return a stale word in place of the next one written.

// File: rtl/tkr_pkg.sv
package tkr_pkg;

  // Per-slice status, both flags active low.
  typedef struct packed {
    logic full_n;
    logic empty_n;
  } slice_flags_t;

  // Index of the ring neighbour that feeds slice i.
  function automatic int ring_prev(input int i, input int n);
    return (i == 0) ? n - 1 : i - 1;
  endfunction

endpackage

// File: rtl/ring_token.sv
// Ownership token plus address pointer for one direction of one slice.
module ring_token #(
  parameter int DEPTH = 2048,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          first_load_n,
  input  logic          xi,
  input  logic          step,
  output logic          tok,
  output logic [AW-1:0] ptr,
  output logic          xo
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic use_here;
  assign use_here = step & tok;
  // Hand-off pulse coincides with the access to the last location.
  assign xo = use_here & (ptr == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tok <= ~first_load_n;
      ptr <= '0;
    end else begin
      if (use_here) ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
      if (xi)       tok <= 1'b1;
      else if (xo)  tok <= 1'b0;
    end
  end
endmodule

// File: rtl/ring_store.sv
// Slice storage: one synchronous write port, one asynchronous read port.
module ring_store #(
  parameter int DATA_W = 9,
  parameter int DEPTH  = 2048,
  parameter int AW     = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/ring_slice.sv
// One slice of the ring: storage, two tokens, occupancy, gated output.
module ring_slice
  import tkr_pkg::*;
#(
  parameter int DATA_W = 9,
  parameter int DEPTH  = 2048,
  parameter int AW     = $clog2(DEPTH),
  parameter int CW     = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              first_load_n,
  input  logic              wr_fire,
  input  logic              rd_fire,
  input  logic              wr_xi,
  input  logic              rd_xi,
  input  logic [DATA_W-1:0] din,
  output logic              wr_xo,
  output logic              rd_xo,
  output logic              wr_tok,
  output logic              rd_tok,
  output logic [DATA_W-1:0] dout,
  output slice_flags_t      flags
);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  logic [AW-1:0]     wptr, rptr;
  logic [DATA_W-1:0] rword;
  logic [CW-1:0]     occ;
  logic              we, re;

  assign we = wr_fire & wr_tok;
  assign re = rd_fire & rd_tok;

  ring_token #(.DEPTH(DEPTH), .AW(AW)) u_wtok (
    .clk(clk), .rst_n(rst_n), .first_load_n(first_load_n),
    .xi(wr_xi), .step(wr_fire), .tok(wr_tok), .ptr(wptr), .xo(wr_xo)
  );

  ring_token #(.DEPTH(DEPTH), .AW(AW)) u_rtok (
    .clk(clk), .rst_n(rst_n), .first_load_n(first_load_n),
    .xi(rd_xi), .step(rd_fire), .tok(rd_tok), .ptr(rptr), .xo(rd_xo)
  );

  ring_store #(.DATA_W(DATA_W), .DEPTH(DEPTH), .AW(AW)) u_mem (
    .clk(clk), .we(we), .waddr(wptr), .wdata(din),
    .raddr(rptr), .rdata(rword)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      occ <= '0;
    end else begin
      unique case ({we, re})
        2'b10:   occ <= occ + 1'b1;
        2'b01:   occ <= occ - 1'b1;
        default: occ <= occ;
      endcase
    end
  end

  assign flags.full_n  = (occ != FULL_CNT);
  assign flags.empty_n = (occ != '0);
  // Slices without the read token put zeros on their share of the bus.
  assign dout = rd_tok ? rword : '0;
endmodule

// File: rtl/ring_flag_merge.sv
// Composite active-low flags: physical OR across all slices.
module ring_flag_merge
  import tkr_pkg::*;
#(
  parameter int N_SLICES = 3
) (
  input  slice_flags_t flags [N_SLICES],
  output logic         full_n,
  output logic         empty_n
);
  always_comb begin
    full_n  = 1'b0;
    empty_n = 1'b0;
    for (int i = 0; i < N_SLICES; i++) begin
      full_n  = full_n  | flags[i].full_n;
      empty_n = empty_n | flags[i].empty_n;
    end
  end
endmodule

// File: rtl/token_ring_fifo.sv
module token_ring_fifo
  import tkr_pkg::*;
#(
  parameter int DATA_W      = 9,
  parameter int SLICE_DEPTH = 2048,
  parameter int N_SLICES    = 3,
  parameter int FIRST_SLICE = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              full_n,
  output logic              empty_n
);
  logic [N_SLICES-1:0] wr_tok_v, rd_tok_v, wr_xo_v, rd_xo_v;
  slice_flags_t        slice_flags [N_SLICES];
  logic [DATA_W-1:0]   slice_dout  [N_SLICES];
  logic                wr_fire, rd_fire;

  assign wr_fire = in_valid & full_n;
  assign rd_fire = out_ready & empty_n;

  for (genvar i = 0; i < N_SLICES; i++) begin : g_slice
    localparam int PREV = ring_prev(i, N_SLICES);
    ring_slice #(.DATA_W(DATA_W), .DEPTH(SLICE_DEPTH)) u_slice (
      .clk          (clk),
      .rst_n        (rst_n),
      .first_load_n (i != FIRST_SLICE),
      .wr_fire      (wr_fire),
      .rd_fire      (rd_fire),
      .wr_xi        (wr_xo_v[PREV]),
      .rd_xi        (rd_xo_v[PREV]),
      .din          (in_data),
      .wr_xo        (wr_xo_v[i]),
      .rd_xo        (rd_xo_v[i]),
      .wr_tok       (wr_tok_v[i]),
      .rd_tok       (rd_tok_v[i]),
      .dout         (slice_dout[i]),
      .flags        (slice_flags[i])
    );
  end

  ring_flag_merge #(.N_SLICES(N_SLICES)) u_flags (
    .flags(slice_flags), .full_n(full_n), .empty_n(empty_n)
  );

  // Wired-OR data-out bus.
  always_comb begin
    out_data = '0;
    for (int i = 0; i < N_SLICES; i++) out_data = out_data | slice_dout[i];
  end

  assign in_ready  = full_n;
  assign out_valid = empty_n;
endmodule

// File: rtl/token_ring_fifo_chk.sv
module token_ring_fifo_chk #(
  parameter int N_SLICES    = 3,
  parameter int FIRST_SLICE = 0
) (
  input logic                clk,
  input logic                rst_n,
  input logic                in_valid,
  input logic                in_ready,
  input logic                out_valid,
  input logic                out_ready,
  input logic                full_n,
  input logic                empty_n,
  input logic [N_SLICES-1:0] wr_tok_v,
  input logic [N_SLICES-1:0] rd_tok_v,
  input logic [N_SLICES-1:0] wr_xo_v,
  input logic [N_SLICES-1:0] rd_xo_v
);
  localparam logic [N_SLICES-1:0] HOME = N_SLICES'(1) << FIRST_SLICE;

  function automatic logic [N_SLICES-1:0] rotl(input logic [N_SLICES-1:0] v);
    return (v << 1) | (v >> (N_SLICES - 1));
  endfunction

  // R5: tokens start at home and queue is empty right after reset release
  a_r5_reset_home: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (wr_tok_v == HOME && rd_tok_v == HOME && !empty_n && full_n));

  // R6: exactly one owner per direction
  a_r6_one_owner: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(wr_tok_v) == 1 && $countones(rd_tok_v) == 1);

  // R6: hand-off moves write token one step around the ring
  a_r6_wr_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_xo_v != '0) |=> (wr_tok_v == rotl($past(wr_tok_v))));

  // R6: hand-off moves read token one step around the ring
  a_r6_rd_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_xo_v != '0) |=> (rd_tok_v == rotl($past(rd_tok_v))));

  // R3: write offered while full leaves the write token in place
  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_ready) |=> $stable(wr_tok_v));

  // R4: read request while empty leaves the read token in place
  a_r4_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    (out_ready && !out_valid) |=> $stable(rd_tok_v));

  // R9: the composite flags never claim full and empty together
  a_r9_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !full_n |-> empty_n);
endmodule

bind token_ring_fifo token_ring_fifo_chk #(
  .N_SLICES(N_SLICES), .FIRST_SLICE(FIRST_SLICE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .full_n(full_n),
  .empty_n(empty_n), .wr_tok_v(wr_tok_v), .rd_tok_v(rd_tok_v),
  .wr_xo_v(wr_xo_v), .rd_xo_v(rd_xo_v)
);

// File: tb/token_ring_fifo_test.sv
`timescale 1ns/1ps
module token_ring_fifo_test;
  localparam int DW  = 9;
  localparam int SD  = 16;
  localparam int NS  = 3;
  localparam int CAP = SD * NS;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, out_ready = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic in_ready, out_valid, full_n, empty_n;
  logic [DW-1:0] out_data;

  int tests = 0, fails = 0;
  logic done = 1'b0;

  logic [DW-1:0] mq [64];
  int head = 0, cnt = 0;

  always #10 clk = ~clk;

  token_ring_fifo #(.DATA_W(DW), .SLICE_DEPTH(SD), .N_SLICES(NS), .FIRST_SLICE(1)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .full_n(full_n), .empty_n(empty_n)
  );

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic exp_nonempty();
    return cnt != 0;
  endfunction

  function automatic logic exp_notfull();
    return cnt != CAP;
  endfunction

  // Check visible state, drive one cycle, update the model.
  task automatic cyc(input logic v, input logic [DW-1:0] d, input logic r, input string tag);
    logic wf, rf;
    chk(out_valid === exp_nonempty(), {tag, " R9 out_valid"}, out_valid, exp_nonempty());
    chk(in_ready === exp_notfull(), {tag, " R1 in_ready"}, in_ready, exp_notfull());
    chk(empty_n === exp_nonempty(), {tag, " R9 empty_n"}, empty_n, exp_nonempty());
    chk(full_n === exp_notfull(), {tag, " R9 full_n"}, full_n, exp_notfull());
    if (cnt != 0)
      chk(out_data === mq[head], {tag, " R2 R7 head word"}, out_data, mq[head]);
    in_valid = v; in_data = d; out_ready = r;
    @(posedge clk);
    wf = v && (cnt < CAP);
    rf = r && (cnt > 0);
    if (wf) mq[(head + cnt) % 64] = d;
    if (rf) head = (head + 1) % 64;
    cnt = cnt + (wf ? 1 : 0) - (rf ? 1 : 0);
    @(negedge clk);
    in_valid = 1'b0; out_ready = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog: got 0 expected 1");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240917));
    repeat (3) @(negedge clk);
    // R5: state during and after reset
    chk(empty_n === 1'b0 && out_valid === 1'b0, "R5 empty during reset", empty_n, 0);
    chk(full_n === 1'b1 && in_ready === 1'b1, "R5 not full during reset", full_n, 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(empty_n === 1'b0 && full_n === 1'b1, "R5 after release", {empty_n, full_n}, 2'b01);

    // R4: read from empty queue, then one word must come back next
    cyc(1'b0, '0, 1'b1, "R4 empty read");
    cyc(1'b0, '0, 1'b1, "R4 empty read");
    cyc(1'b1, 9'h1A5, 1'b0, "R4 write after");
    chk(out_data === 9'h1A5, "R4 word after empty read", out_data, 9'h1A5);
    // R8: read and write in the same cycle, same slice
    cyc(1'b1, 9'h033, 1'b1, "R8 same cycle");
    chk(out_valid === 1'b1 && out_data === 9'h033, "R8 occupancy kept", out_data, 9'h033);
    cyc(1'b0, '0, 1'b1, "R8 drain");

    // R1 R6: fill to capacity across all slice boundaries
    for (int i = 0; i < CAP; i++) cyc(1'b1, DW'($urandom), 1'b0, "R1 R6 fill");
    chk(in_ready === 1'b0 && full_n === 1'b0, "R1 full at capacity", in_ready, 0);
    // R3: writes offered while full are dropped
    for (int i = 0; i < 4; i++) cyc(1'b1, DW'($urandom), 1'b0, "R3 write when full");
    // R2: full drain in order across boundaries and the wrap
    for (int i = 0; i < CAP; i++) cyc(1'b0, '0, 1'b1, "R2 drain");
    chk(out_valid === 1'b0 && empty_n === 1'b0, "R2 empty after drain", out_valid, 0);

    // Random mixes with shifting bias, tokens go around many times
    for (int ph = 0; ph < 6; ph++) begin
      int wp = (ph % 3 == 0) ? 80 : (ph % 3 == 1) ? 50 : 25;
      for (int i = 0; i < 1500; i++) begin
        logic v = (($urandom % 100) < wp);
        logic r = (($urandom % 100) < 50);
        cyc(v, DW'($urandom), r, "R2 R8 random");
      end
    end

    // Mid-run reset: contents discarded (R5)
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    head = 0; cnt = 0;
    @(negedge clk);
    chk(empty_n === 1'b0 && full_n === 1'b1, "R5 reset clears", {empty_n, full_n}, 2'b01);
    cyc(1'b1, 9'h0F0, 1'b0, "R5 post reset write");
    cyc(1'b0, '0, 1'b1, "R5 post reset read");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule